// File: doc/BRIEF.md
# Power Domain and Module State Sequencer

This block sequences the power domains of a small chip and the clock/reset state of every functional module inside them. Software talks to it over a simple register bus. For each module it writes a requested state into that module's control word. For each domain it can raise a power-on request. It then issues a per-domain transition command and polls the busy and status registers until the change has landed.

A requested module state has no effect on its own. It is applied only when the owning domain's transition command runs to completion. When a command targets a domain that is still off and has a power-on request, the block models an externally switched supply. It raises a per-domain pending flag and stalls until software confirms the supply by setting an acknowledge bit. Power-up then takes a fixed number of cycles, and the module update takes a further fixed number of cycles.

Module `m` belongs to domain `m % NUM_DOM`. The register pages are selected by `bus_addr[11:8]`, and the entry index within a page by `bus_addr[7:2]`. Accesses with `bus_addr[1:0]` not zero are ignored. The pages are:
- page 0: word 0 is the command register (writes only, reads 0), word 1 is busy, word 2 is pending.
- page 1: domain control words.
- page 2: domain status words.
- page 4: module control words, at page base + 4 × module index.
- page 6: module status words, at page base + 4 × module index.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: The module control word at 0x400 + 4·m holds the requested state in bits [2:0], using the encoding 0 = reset-and-disabled, 1 = synchronous reset, 2 = disabled, 3 = enabled. A write updates only that field, and every other bit reads 0.
- R2: Writing a module control word leaves that module's status word (0x600 + 4·m) unchanged until a transition command for the module's domain completes.
- R3: Bit 12 of a module status word reads 1 exactly when the current state field (bits [2:0]) is 1 or 3, and reads 0 for states 0 and 2.
- R4: Bit 0 of the domain status word (0x200 + 4·d) reads 0 while domain d is off and 1 once it is on. Once on, it stays 1 until reset.
- R5: A write to the command register (0x000) with bit d set starts a transition for domain d. Bit d of the busy register (0x004) then reads 1 until the transition completes, and 0 afterwards. A transition on a domain that is on, or that has no power-on request, updates modules only and takes MOD_CYC cycles.
- R6: A command for an off domain whose power-on request (bit 0 of the domain control word at 0x100 + 4·d) is set raises bit d of the pending register (0x008). The domain stays off and busy until the acknowledge (bit 8 of the same control word) is seen set.
- R7: Once the acknowledge is seen, pending clears and the domain turns on PWRUP_CYC cycles later. The transition completes MOD_CYC cycles after that, so busy falls on edge Ea+PWRUP_CYC+MOD_CYC+1, where Ea is the edge that writes the acknowledge.
- R8: When a transition of domain d completes, the state field of every module in d equals its requested state. Modules of other domains keep their state.
- R9: A command for a domain that is already busy is ignored and does not restart or lengthen its transition.
- R10: After reset, all domains are off, and all busy, pending, request, acknowledge, module request and module state fields read 0.
- R11: The read data for a read accepted on one clock edge appears on `bus_rdata` after that edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_vld | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the read |

## Verification
The sequencing is exercised along three paths:
- a cold power-up with the supply handshake,
- a module-only transition on a domain that is already on,
- a transition on a second, unrequested domain.

Together these separate the pending/acknowledge stall from the plain module update, and show that each domain commits only its own modules. The power-up path is timed to the exact edge on which busy falls, which distinguishes a correct power-up plus module-update count from an off-by-one. Repeated commands issued into a running transition show whether a busy domain restarts. Module requests written without a command show whether a state can leak out before the domain transition completes.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int STATE_W = 3;
  localparam int IDX_W   = 6;

  // register pages selected by bus_addr[11:8]
  localparam logic [3:0] PG_GLOBAL = 4'h0;
  localparam logic [3:0] PG_DCTL   = 4'h1;
  localparam logic [3:0] PG_DSTAT  = 4'h2;
  localparam logic [3:0] PG_MCTL   = 4'h4;
  localparam logic [3:0] PG_MSTAT  = 4'h6;

  // words inside the global page
  localparam logic [IDX_W-1:0] GW_CMD  = 6'd0;
  localparam logic [IDX_W-1:0] GW_BUSY = 6'd1;
  localparam logic [IDX_W-1:0] GW_PEND = 6'd2;

  // bit positions software depends on
  localparam int DCTL_REQ_BIT = 0;
  localparam int DCTL_ACK_BIT = 8;
  localparam int MSTAT_CLK_BIT = 12;

  typedef enum logic [1:0] {
    DS_IDLE,
    DS_WAIT_ACK,
    DS_PWRUP,
    DS_MODS
  } dom_state_e;

  function automatic logic clk_running(input logic [STATE_W-1:0] st);
    return (st == 3'd1) || (st == 3'd3);
  endfunction

endpackage

// File: rtl/pwr_seq_rst_sync.sv
module pwr_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pwr_seq_dom_fsm.sv
module pwr_seq_dom_fsm
  import pwr_seq_pkg::*;
#(
  parameter int PWRUP_CYC = 4,
  parameter int MOD_CYC   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic pwr_req_i,
  input  logic ack_i,
  output logic busy_o,
  output logic pend_o,
  output logic on_o,
  output logic commit_o
);
  localparam int MAX_CYC = (PWRUP_CYC > MOD_CYC) ? PWRUP_CYC : MOD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  dom_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             on_q, on_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    on_d     = on_q;
    commit_o = 1'b0;
    unique case (state_q)
      DS_IDLE: begin
        if (cmd_i) begin
          if (!on_q && pwr_req_i) begin
            state_d = DS_WAIT_ACK;
          end else begin
            state_d = DS_MODS;
            cnt_d   = CNT_W'(MOD_CYC - 1);
          end
        end
      end
      DS_WAIT_ACK: begin
        if (ack_i) begin
          state_d = DS_PWRUP;
          cnt_d   = CNT_W'(PWRUP_CYC - 1);
        end
      end
      DS_PWRUP: begin
        if (cnt_q == '0) begin
          on_d    = 1'b1;
          state_d = DS_MODS;
          cnt_d   = CNT_W'(MOD_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      DS_MODS: begin
        if (cnt_q == '0) begin
          commit_o = 1'b1;
          state_d  = DS_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = DS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DS_IDLE;
      cnt_q   <= '0;
      on_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      on_q    <= on_d;
    end
  end

  assign busy_o = (state_q != DS_IDLE);
  assign pend_o = (state_q == DS_WAIT_ACK);
  assign on_o   = on_q;
endmodule

// File: rtl/pwr_seq_mod_track.sv
module pwr_seq_mod_track
  import pwr_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic [STATE_W-1:0] req_i,
  output logic [STATE_W-1:0] state_o,
  output logic               clk_on_o
);
  logic [STATE_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (commit_i) state_q <= req_i;
  end

  assign state_o  = state_q;
  assign clk_on_o = clk_running(state_q);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NUM_DOM   = 2,
  parameter int NUM_MOD   = 4,
  parameter int PWRUP_CYC = 4,
  parameter int MOD_CYC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic rst_sync_n;

  pwr_seq_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // address decode
  logic             acc_ok, wr_en, rd_en;
  logic [3:0]       page;
  logic [IDX_W-1:0] idx;

  assign page   = bus_addr[11:8];
  assign idx    = bus_addr[7:2];
  assign acc_ok = bus_vld && (bus_addr[1:0] == 2'b00);
  assign wr_en  = acc_ok && bus_we;
  assign rd_en  = acc_ok && !bus_we;

  // domain side
  logic [NUM_DOM-1:0] dom_req_q, dom_ack_q, dom_cmd;
  logic [NUM_DOM-1:0] dom_busy, dom_pend, dom_on, dom_commit;

  assign dom_cmd = (wr_en && page == PG_GLOBAL && idx == GW_CMD)
                 ? bus_wdata[NUM_DOM-1:0] : '0;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic wr_dctl;
    assign wr_dctl = wr_en && (page == PG_DCTL) && (idx == IDX_W'(d));

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        dom_req_q[d] <= 1'b0;
        dom_ack_q[d] <= 1'b0;
      end else if (wr_dctl) begin
        dom_req_q[d] <= bus_wdata[DCTL_REQ_BIT];
        dom_ack_q[d] <= bus_wdata[DCTL_ACK_BIT];
      end
    end

    pwr_seq_dom_fsm #(
      .PWRUP_CYC(PWRUP_CYC),
      .MOD_CYC  (MOD_CYC)
    ) u_dom (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cmd_i    (dom_cmd[d]),
      .pwr_req_i(dom_req_q[d]),
      .ack_i    (dom_ack_q[d]),
      .busy_o   (dom_busy[d]),
      .pend_o   (dom_pend[d]),
      .on_o     (dom_on[d]),
      .commit_o (dom_commit[d])
    );
  end

  // module side: module m sits in domain m % NUM_DOM
  logic [NUM_MOD-1:0][STATE_W-1:0] mod_req_q, mod_state;
  logic [NUM_MOD-1:0]              mod_clk_on;

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    logic wr_mctl;
    assign wr_mctl = wr_en && (page == PG_MCTL) && (idx == IDX_W'(m));

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  mod_req_q[m] <= '0;
      else if (wr_mctl) mod_req_q[m] <= bus_wdata[STATE_W-1:0];
    end

    pwr_seq_mod_track u_trk (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .commit_i(dom_commit[m % NUM_DOM]),
      .req_i   (mod_req_q[m]),
      .state_o (mod_state[m]),
      .clk_on_o(mod_clk_on[m])
    );
  end

  // read path
  logic [DATA_W-1:0] rd_word, rdata_q;

  always_comb begin
    rd_word = '0;
    unique case (page)
      PG_GLOBAL: begin
        if (idx == GW_BUSY) rd_word = DATA_W'(dom_busy);
        if (idx == GW_PEND) rd_word = DATA_W'(dom_pend);
      end
      PG_DCTL: begin
        for (int d = 0; d < NUM_DOM; d++) begin
          if (idx == IDX_W'(d)) begin
            rd_word[DCTL_REQ_BIT] = dom_req_q[d];
            rd_word[DCTL_ACK_BIT] = dom_ack_q[d];
          end
        end
      end
      PG_DSTAT: begin
        for (int d = 0; d < NUM_DOM; d++) begin
          if (idx == IDX_W'(d)) rd_word[0] = dom_on[d];
        end
      end
      PG_MCTL: begin
        for (int m = 0; m < NUM_MOD; m++) begin
          if (idx == IDX_W'(m)) rd_word[STATE_W-1:0] = mod_req_q[m];
        end
      end
      PG_MSTAT: begin
        for (int m = 0; m < NUM_MOD; m++) begin
          if (idx == IDX_W'(m)) begin
            rd_word[STATE_W-1:0]   = mod_state[m];
            rd_word[MSTAT_CLK_BIT] = mod_clk_on[m];
          end
        end
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk
  import pwr_seq_pkg::*;
#(
  parameter int NUM_DOM = 2,
  parameter int NUM_MOD = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_DOM-1:0]              busy,
  input logic [NUM_DOM-1:0]              pend,
  input logic [NUM_DOM-1:0]              dom_on,
  input logic [NUM_MOD-1:0][STATE_W-1:0] mod_req,
  input logic [NUM_MOD-1:0][STATE_W-1:0] mod_state
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dchk
    p_pend_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pend[d] |-> busy[d]);
    p_pend_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[d]) |-> !dom_on[d]);
    p_on_in_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_on[d]) |-> (busy[d] && !pend[d]));
    p_on_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dom_on[d] |=> dom_on[d]);
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mchk
    p_commit_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[m % NUM_DOM]) |-> (mod_state[m] == $past(mod_req[m])));
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[m % NUM_DOM] |=> $stable(mod_state[m]));
  end
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(
  .NUM_DOM(NUM_DOM),
  .NUM_MOD(NUM_MOD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .busy     (dom_busy),
  .pend     (dom_pend),
  .dom_on   (dom_on),
  .mod_req  (mod_req_q),
  .mod_state(mod_state)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_DOM = 2;
  localparam int N_MOD = 4;
  localparam int P_CYC = 4;
  localparam int M_CYC = 3;

  localparam logic [11:0] A_CMD  = 12'h000;
  localparam logic [11:0] A_BUSY = 12'h004;
  localparam logic [11:0] A_PEND = 12'h008;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_vld, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(
    .NUM_DOM(N_DOM), .NUM_MOD(N_MOD), .PWRUP_CYC(P_CYC), .MOD_CYC(M_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [11:0] a_dctl(int d);  return 12'h100 + 12'(4*d); endfunction
  function automatic logic [11:0] a_dstat(int d); return 12'h200 + 12'(4*d); endfunction
  function automatic logic [11:0] a_mctl(int m);  return 12'h400 + 12'(4*m); endfunction
  function automatic logic [11:0] a_mstat(int m); return 12'h600 + 12'(4*m); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all bus tasks start and end on a falling edge; one cycle each
  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    bus_vld = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    bus_vld = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_vld = 1'b0;
    d = bus_rdata;   // R11: data of the read accepted on the edge just passed
  endtask

  task automatic read_check(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic wait_idle(string req, int d);
    logic [31:0] v;
    bit idle = 1'b0;
    for (int i = 0; i < 200 && !idle; i++) begin
      bus_read(A_BUSY, v);
      idle = !v[d];
    end
    check(req, 32'(idle), 32'd1);
  endtask

  task automatic t_reset_state;
    read_check("R10 busy", A_BUSY, 32'h0);
    read_check("R10 pending", A_PEND, 32'h0);
    read_check("R4 dom0 off", a_dstat(0), 32'h0);
    read_check("R4 dom1 off", a_dstat(1), 32'h0);
    read_check("R10 dctl0", a_dctl(0), 32'h0);
    read_check("R10 mstat0", a_mstat(0), 32'h0);
    read_check("R10 mctl3", a_mctl(3), 32'h0);
  endtask

  task automatic t_field_write;
    bus_write(a_mctl(0), 32'hFFFF_FFFB);
    bus_write(a_mctl(2), 32'hFFFF_FFF9);
    read_check("R1 mctl0 field only", a_mctl(0), 32'h3);
    read_check("R1 mctl2 field only", a_mctl(2), 32'h1);
    read_check("R2 mstat0 before cmd", a_mstat(0), 32'h0);
    read_check("R2 mstat2 before cmd", a_mstat(2), 32'h0);
  endtask

  task automatic t_powerup;
    bus_write(a_dctl(0), 32'h1);
    bus_write(A_CMD, 32'h1);
    read_check("R6 pending set", A_PEND, 32'h1);
    read_check("R6 dom0 still off", a_dstat(0), 32'h0);
    repeat (12) @(negedge clk);
    read_check("R6 still pending", A_PEND, 32'h1);
    read_check("R6 still busy", A_BUSY, 32'h1);
    read_check("R2 mstat0 during wait", a_mstat(0), 32'h0);
    bus_write(a_dctl(0), 32'h101);                 // acknowledge at edge Ea
    repeat (P_CYC + M_CYC) @(negedge clk);
    read_check("R7 busy at last edge", A_BUSY, 32'h1);
    read_check("R7 busy falls on time", A_BUSY, 32'h0);
    read_check("R7 pending cleared", A_PEND, 32'h0);
    read_check("R4 dom0 on", a_dstat(0), 32'h1);
    read_check("R8 R3 mstat0 enabled", a_mstat(0), 32'h0000_1003);
    read_check("R8 R3 mstat2 sync reset", a_mstat(2), 32'h0000_1001);
    read_check("R8 mstat1 other domain", a_mstat(1), 32'h0);
    read_check("R10 dctl0 readback", a_dctl(0), 32'h101);
  endtask

  task automatic t_busy_ignore;
    bus_write(a_mctl(0), 32'h2);
    bus_write(A_CMD, 32'h1);     // E0: starts, ends on E0+MOD_CYC
    bus_write(A_CMD, 32'h1);     // ignored
    bus_write(A_CMD, 32'h1);     // ignored
    @(negedge clk);
    read_check("R9 no restart", A_BUSY, 32'h0);
    read_check("R3 R5 mstat0 disabled", a_mstat(0), 32'h0000_0002);
    read_check("R4 dom0 stays on", a_dstat(0), 32'h1);
  endtask

  task automatic t_busy_visible;
    bus_write(A_CMD, 32'h1);
    read_check("R5 busy after cmd", A_BUSY, 32'h1);
    read_check("R5 no pending when on", A_PEND, 32'h0);
    wait_idle("R5 completes", 0);
    read_check("R5 busy cleared", A_BUSY, 32'h0);
  endtask

  task automatic t_other_domain;
    bus_write(a_mctl(1), 32'h2);
    bus_write(a_mctl(3), 32'h3);
    bus_write(A_CMD, 32'h2);
    read_check("R5 dom1 busy only", A_BUSY, 32'h2);
    read_check("R6 no pending without request", A_PEND, 32'h0);
    wait_idle("R5 dom1 completes", 1);
    read_check("R8 R3 mstat1", a_mstat(1), 32'h0000_0002);
    read_check("R8 R3 mstat3", a_mstat(3), 32'h0000_1003);
    read_check("R8 mstat0 untouched", a_mstat(0), 32'h0000_0002);
    read_check("R4 dom1 still off", a_dstat(1), 32'h0);
  endtask

  task automatic t_no_effect;
    bus_write(a_mctl(3), 32'h0);
    repeat (8) @(negedge clk);
    read_check("R2 mstat3 held", a_mstat(3), 32'h0000_1003);
    read_check("R1 mctl3 readback", a_mctl(3), 32'h0);
    bus_write(A_CMD, 32'h2);
    wait_idle("R5 dom1 second run", 1);
    read_check("R8 R3 mstat3 reset-disabled", a_mstat(3), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_vld = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_field_write();
    t_powerup();
    t_busy_ignore();
    t_busy_visible();
    t_other_domain();
    t_no_effect();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule